// File: doc/BRIEF.md
# Configuration Cycle Address Generator

This block sits between a host-side configuration request port and a single-beat bus port. It turns a request into an address in the sparse configuration window. A request carries a bus number, a device/function byte, a register offset, an access size, a direction and write data. On bus zero the block builds a type 0 address, where the device is chosen by a one-hot select bit. On any other bus it builds a type 1 address, which carries the bus, device and function numbers as fields. The block places write data on the correct byte lanes and pulls read data from the correct lanes. A read that the bus aborts returns all-ones.

Misaligned requests and devices outside the allowed range on bus zero end without any bus cycle. Only a misaligned request is reported as a bad register. The controller handles one request at a time and has three states:

- `ST_IDLE` waits for a request.
- `ST_BUS` holds the bus request until the bus completes it.
- `ST_ACK` drives the one-cycle acknowledge.

The transitions are:

- `ST_IDLE` to `ST_BUS` on an accepted, valid request.
- `ST_IDLE` to `ST_ACK` on a rejected request.
- `ST_BUS` to `ST_ACK` when the bus reports done.
- `ST_ACK` to `ST_IDLE` always.

Top module: `cfg_addr_gen`

## Requirements
- R1: A request with bus number 0 gives a type 0 configuration word. The device is devfn[7:3], and exactly one select bit is set, at bit 11 plus the device. The word carries devfn[2:0] in bits [10:8], offset[7:2] in bits [7:2], and 00 in bits [1:0].
- R2: On bus 0, a device above 8 issues no bus cycle. The request is still acknowledged with bad-register clear. A read returns all-ones at the access width and a write returns zero. Device 8 itself is accepted.
- R3: A nonzero bus gives a type 1 configuration word. It carries the bus in bits [23:16], devfn in bits [15:8] and offset[7:2] in bits [7:2]. Bits [31:24] are zero and bits [1:0] are 01.
- R4: The bus address is CFG_BASE ORed with the configuration word shifted left by 5, plus a size code. The size field is 0 for a byte, 1 for a word, and 2 or 3 for a dword. The code is 0x00 for a byte, 0x08 for a word and 0x18 for a dword.
- R5: Two cases are misaligned: a word with offset[0] set, and a dword with offset[1:0] nonzero. Either case, read or write, is acknowledged with bad-register set and no bus cycle. A read returns all-ones at the access width. Misalignment is checked before the device range.
- R6: Write data is masked to the access width and shifted left by 8 times offset[1:0], keeping 32 bits.
- R7: Read data is shifted right by 8 times offset[1:0] and masked to the access width.
- R8: A bus abort on a read makes the result all-ones at the access width. An abort on a write is ignored: the write returns zero with bad-register clear.
- R9: The acknowledge lasts exactly one cycle and carries the read data and status. Requests presented while busy are ignored. The bus request and its address and data are held until bus done.
- R10: A synchronous active-low reset clears every output and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device [7:3] and function [2:0] |
| req_offset | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, right-aligned |
| req_ack | output | 1 | One-cycle completion |
| rsp_rdata | output | 32 | Read result, right-aligned; zero for writes |
| rsp_bad_reg | output | 1 | Misaligned request status |
| bus_valid | output | 1 | Bus request, held until bus_done |
| bus_addr | output | ADDR_W | Sparse configuration address |
| bus_write | output | 1 | Bus direction |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_done | input | 1 | Bus completion, sampled in ST_BUS |
| bus_rdata | input | 32 | Bus read data, valid with bus_done |
| bus_abort | input | 1 | Abort or error, valid with bus_done |

## Verification
A request strobed at one edge shows its effect right after that edge. For an accepted request, bus_valid, bus_addr and bus_wdata appear then. For a rejected request, req_ack appears then together with the status and data. For an accepted request, req_ack with the read result appears one edge after bus_done is sampled, and drops at the following edge. The bench holds a behavioural model of these deadlines. On each falling clock edge it compares every output against that model, including each wait cycle and the cycle after acknowledge, so early, late or doubled responses are caught.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_ACK  = 2'd2
    } state_e;

    localparam int CFG_W     = 32;
    localparam int CFG_SHIFT = 5;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: lane_mask = 32'h0000_00FF;
            SZ_WORD: lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_addr_build.sv
module cfg_addr_build
    import cfg_pkg::*;
#(
    parameter int              ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] CFG_BASE = '0,
    parameter int              MAX_DEV0 = 8
) (
    input  logic [7:0]        bus_num,
    input  logic [7:0]        devfn,
    input  logic [7:0]        offset,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] addr,
    output logic              dev_ok,
    output logic              align_ok
);
    localparam logic [4:0] DEV_LIMIT = 5'(MAX_DEV0);

    logic [4:0]       dev;
    logic             type0;
    logic [CFG_W-1:0] cfg_word;
    logic [CFG_W-1:0] sel_bits;
    logic [ADDR_W-1:0] code;

    assign dev   = devfn[7:3];
    assign type0 = (bus_num == 8'd0);

    always_comb begin
        sel_bits = 32'h0000_0800 << dev;
        if (type0)
            cfg_word = sel_bits | {21'd0, devfn[2:0], offset[7:2], 2'b00};
        else
            cfg_word = {8'd0, bus_num, devfn, offset[7:2], 2'b01};
    end

    always_comb begin
        case (size)
            SZ_BYTE: code = ADDR_W'(5'h00);
            SZ_WORD: code = ADDR_W'(5'h08);
            default: code = ADDR_W'(5'h18);
        endcase
    end

    assign addr = (CFG_BASE | (ADDR_W'(cfg_word) << CFG_SHIFT)) + code;

    assign dev_ok = !type0 || (dev <= DEV_LIMIT);

    always_comb begin
        case (size)
            SZ_BYTE: align_ok = 1'b1;
            SZ_WORD: align_ok = !offset[0];
            default: align_ok = (offset[1:0] == 2'b00);
        endcase
    end

endmodule

// File: rtl/cfg_lane_align.sv
module cfg_lane_align
    import cfg_pkg::*;
(
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    input  logic [31:0] wdata_in,
    output logic [31:0] wdata_out,
    input  logic [31:0] rdata_in,
    input  logic        force_ones,
    output logic [31:0] rdata_out
);
    logic [4:0]  sh;
    logic [31:0] mask;
    logic [31:0] rsrc;

    assign sh        = {lane, 3'b000};
    assign mask      = lane_mask(size);
    assign wdata_out = (wdata_in & mask) << sh;
    assign rsrc      = force_ones ? 32'hFFFF_FFFF : rdata_in;
    assign rdata_out = (rsrc >> sh) & mask;

endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
    import cfg_pkg::*;
#(
    parameter int                ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] CFG_BASE = 40'h80_0000_0000,
    parameter int                MAX_DEV0 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_bus,
    input  logic [7:0]        req_devfn,
    input  logic [7:0]        req_offset,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              req_ack,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_bad_reg,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [31:0]       bus_wdata,
    input  logic              bus_done,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_abort
);
    localparam int SEL_LO = CFG_SHIFT + 11;
    localparam int SEL_HI = CFG_SHIFT + 31;
    localparam int TOP_LO = CFG_SHIFT + 24;

    state_e state, state_nx;

    logic [1:0]        lat_lane;
    logic [1:0]        lat_size;
    logic              lat_write;
    logic [ADDR_W-1:0] b_addr;
    logic              b_dev_ok;
    logic              b_align_ok;
    logic [1:0]        al_lane;
    logic [1:0]        al_size;
    logic [31:0]       al_wdata;
    logic [31:0]       al_rdata;
    logic              accept_ok;

    cfg_addr_build #(
        .ADDR_W  (ADDR_W),
        .CFG_BASE(CFG_BASE),
        .MAX_DEV0(MAX_DEV0)
    ) i_build (
        .bus_num (req_bus),
        .devfn   (req_devfn),
        .offset  (req_offset),
        .size    (req_size),
        .addr    (b_addr),
        .dev_ok  (b_dev_ok),
        .align_ok(b_align_ok)
    );

    assign al_lane = (state == ST_IDLE) ? req_offset[1:0] : lat_lane;
    assign al_size = (state == ST_IDLE) ? req_size : lat_size;

    cfg_lane_align i_align (
        .lane      (al_lane),
        .size      (al_size),
        .wdata_in  (req_wdata),
        .wdata_out (al_wdata),
        .rdata_in  (bus_rdata),
        .force_ones(bus_abort),
        .rdata_out (al_rdata)
    );

    assign accept_ok = b_dev_ok && b_align_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = accept_ok ? ST_BUS : ST_ACK;
            ST_BUS:  if (bus_done)  state_nx = ST_ACK;
            ST_ACK:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_ack     <= 1'b0;
            rsp_rdata   <= '0;
            rsp_bad_reg <= 1'b0;
            bus_valid   <= 1'b0;
            bus_addr    <= '0;
            bus_write   <= 1'b0;
            bus_wdata   <= '0;
            lat_lane    <= '0;
            lat_size    <= '0;
            lat_write   <= 1'b0;
        end else begin
            req_ack     <= 1'b0;
            rsp_rdata   <= '0;
            rsp_bad_reg <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_lane  <= req_offset[1:0];
                        lat_size  <= req_size;
                        lat_write <= req_write;
                        if (accept_ok) begin
                            bus_valid <= 1'b1;
                            bus_addr  <= b_addr;
                            bus_write <= req_write;
                            bus_wdata <= req_write ? al_wdata : 32'd0;
                        end else begin
                            req_ack     <= 1'b1;
                            rsp_bad_reg <= !b_align_ok;
                            rsp_rdata   <= req_write ? 32'd0 : lane_mask(req_size);
                        end
                    end
                end
                ST_BUS: begin
                    if (bus_done) begin
                        bus_valid <= 1'b0;
                        bus_addr  <= '0;
                        bus_write <= 1'b0;
                        bus_wdata <= '0;
                        req_ack   <= 1'b1;
                        rsp_rdata <= lat_write ? 32'd0 : al_rdata;
                    end
                end
                ST_ACK: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R9: acknowledge is a single-cycle pulse
    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R9: bus request and its payload hold until done
    a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata)));

    // R9: a bus cycle only starts from a host request
    a_r9_issue_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(req_valid));

    // R5: a bad-register response never follows a bus cycle
    a_r5_no_cycle_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && rsp_bad_reg) |-> !$past(bus_valid));

    // R1: type 0 select field is one-hot
    a_r1_select_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_addr[CFG_SHIFT]) |-> $onehot(bus_addr[SEL_HI:SEL_LO]));

    // R3: type 1 upper byte is zero and bit 1 clear
    a_r3_type1_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[CFG_SHIFT]) |-> (bus_addr[SEL_HI:TOP_LO] == '0 && !bus_addr[CFG_SHIFT+1]));

    // R4: size code is one of three legal values
    a_r4_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[4:0] == 5'h00 || bus_addr[4:0] == 5'h08 || bus_addr[4:0] == 5'h18));

endmodule

// File: tb/test_cfg_addr_gen.sv
module test_cfg_addr_gen;
    localparam int AW = 40;
    localparam logic [AW-1:0] BASE = 40'h80_0000_0000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [7:0]    req_bus, req_devfn, req_offset;
    logic [1:0]    req_size;
    logic          req_write;
    logic [31:0]   req_wdata;
    logic          req_ack;
    logic [31:0]   rsp_rdata;
    logic          rsp_bad_reg;
    logic          bus_valid;
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic [31:0]   bus_wdata;
    logic          bus_done;
    logic [31:0]   bus_rdata;
    logic          bus_abort;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cfg_addr_gen #(.ADDR_W(AW), .CFG_BASE(BASE), .MAX_DEV0(8)) i_cfg_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_offset(req_offset), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .rsp_bad_reg(rsp_bad_reg), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .bus_abort(bus_abort)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_mask(input logic [1:0] sz);
        if (sz == 2'd0) return 32'hFF;
        if (sz == 2'd1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [63:0] m_addr(input logic [7:0] b, input logic [7:0] dfn,
                                           input logic [7:0] off, input logic [1:0] sz);
        longint cfg;
        longint code;
        if (b == 0) cfg = (longint'(1) << (11 + dfn[7:3])) | (longint'(dfn[2:0]) << 8) | longint'(off & 8'hFC);
        else        cfg = (longint'(b) << 16) | (longint'(dfn) << 8) | longint'(off & 8'hFC) | 1;
        code = (sz == 0) ? 0 : (sz == 1) ? 8 : 24;
        return 64'((longint'(BASE) | (cfg << 5)) + code);
    endfunction

    task automatic xact(input string tag, input logic [7:0] b, input logic [7:0] dfn,
                        input logic [7:0] off, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input int dly, input bit ab,
                        input logic [31:0] rd, input bit noise);
        bit bad, rej;
        int sh;
        logic [63:0] ea;
        logic [31:0] er;
        bad = (sz == 1 && off[0]) || (sz >= 2 && off[1:0] != 0);
        rej = bad || (b == 0 && dfn[7:3] > 8);
        sh  = 8 * off[1:0];
        ea  = m_addr(b, dfn, off, sz);
        @(negedge clk);
        req_bus = b; req_devfn = dfn; req_offset = off; req_size = sz;
        req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (rej) begin
            chk({tag, " reject ack"}, 64'(req_ack), 64'd1);
            chk({tag, " reject status"}, 64'(rsp_bad_reg), 64'(bad));
            chk({tag, " reject data"}, 64'(rsp_rdata), 64'(wr ? 32'd0 : m_mask(sz)));
            chk({tag, " reject no bus"}, 64'(bus_valid), 64'd0);
            @(negedge clk);
            chk({tag, " ack drop"}, 64'(req_ack), 64'd0);
            chk({tag, " still no bus"}, 64'(bus_valid), 64'd0);
        end else begin
            chk({tag, " bus valid"}, 64'(bus_valid), 64'd1);
            chk({tag, " address"}, 64'(bus_addr), ea);
            chk({tag, " direction"}, 64'(bus_write), 64'(wr));
            chk({tag, " lanes"}, 64'(bus_wdata), 64'(wr ? ((wd & m_mask(sz)) << sh) : 32'd0));
            chk({tag, " no early ack"}, 64'(req_ack), 64'd0);
            for (int i = 0; i < dly; i++) begin
                if (noise) begin
                    req_valid = 1'b1; req_bus = 8'h00; req_devfn = 8'h08;
                    req_offset = 8'h00; req_size = 2'd2; req_write = 1'b1;
                end
                @(negedge clk);
                chk({tag, " R9 hold valid"}, 64'(bus_valid), 64'd1);
                chk({tag, " R9 hold addr"}, 64'(bus_addr), ea);
                chk({tag, " R9 wait no ack"}, 64'(req_ack), 64'd0);
            end
            req_valid = 1'b0;
            bus_done = 1'b1; bus_abort = ab; bus_rdata = rd;
            @(negedge clk);
            bus_done = 1'b0; bus_abort = 1'b0; bus_rdata = 32'h0BAD_F00D;
            if (wr) er = 32'd0;
            else if (ab) er = m_mask(sz);
            else er = (rd >> sh) & m_mask(sz);
            chk({tag, " done ack"}, 64'(req_ack), 64'd1);
            chk({tag, " result"}, 64'(rsp_rdata), 64'(er));
            chk({tag, " status ok"}, 64'(rsp_bad_reg), 64'd0);
            chk({tag, " bus released"}, 64'(bus_valid), 64'd0);
            @(negedge clk);
            chk({tag, " R9 ack one cycle"}, 64'(req_ack), 64'd0);
            if (noise) begin
                repeat (2) begin
                    @(negedge clk);
                    chk({tag, " R9 busy request ignored"}, 64'(bus_valid), 64'd0);
                    chk({tag, " R9 no stray ack"}, 64'(req_ack), 64'd0);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; req_bus = 8'h00; req_devfn = 8'h00;
        req_offset = 8'h00; req_size = 2'd2; req_write = 1'b0; req_wdata = '0;
        bus_done = 1'b0; bus_rdata = '0; bus_abort = 1'b0;
        repeat (3) @(negedge clk);
        // R10: outputs zero under reset even with a request present
        chk("R10 ack", 64'(req_ack), 64'd0);
        chk("R10 bus_valid", 64'(bus_valid), 64'd0);
        chk("R10 bus_addr", 64'(bus_addr), 64'd0);
        chk("R10 rdata", 64'(rsp_rdata), 64'd0);
        chk("R10 wdata", 64'(bus_wdata | {31'd0, bus_write} | {31'd0, rsp_bad_reg}), 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;

        xact("R1 R4 R7 t0 dword read",  8'd0, {5'd3, 3'd2}, 8'h10, 2'd2, 0, 0, 0, 0, 32'h1234_5678, 0);
        xact("R1 R4 R7 t0 byte read",   8'd0, {5'd0, 3'd1}, 8'h13, 2'd0, 0, 0, 0, 0, 32'hA1B2_C3D4, 0);
        xact("R1 R4 R7 t0 word read",   8'd0, {5'd5, 3'd0}, 8'h22, 2'd1, 0, 0, 2, 0, 32'hCAFE_BEEF, 0);
        xact("R3 R6 t1 dword write",    8'd5, 8'hA9, 8'h44, 2'd2, 1, 32'hDEAD_BEEF, 1, 0, 0, 0);
        xact("R3 R6 t1 byte write",     8'd1, 8'h10, 8'h3D, 2'd0, 1, 32'h00AB_CD55, 0, 0, 0, 0);
        xact("R2 R6 dev8 word write",   8'd0, {5'd8, 3'd7}, 8'h06, 2'd1, 1, 32'hFFFF_9876, 0, 0, 0, 0);
        xact("R3 R7 t1 max fields",     8'hFF, 8'hFF, 8'hFC, 2'd3, 0, 0, 0, 0, 32'h0F0F_1234, 0);
        xact("R2 dev9 byte read",       8'd0, {5'd9, 3'd0}, 8'h01, 2'd0, 0, 0, 0, 0, 0, 0);
        xact("R2 dev31 dword read",     8'd0, {5'd31, 3'd3}, 8'h00, 2'd2, 0, 0, 0, 0, 0, 0);
        xact("R2 dev9 write discarded", 8'd0, {5'd9, 3'd0}, 8'h00, 2'd2, 1, 32'h1111_2222, 0, 0, 0, 0);
        xact("R5 word misaligned",      8'd0, {5'd1, 3'd0}, 8'h01, 2'd1, 0, 0, 0, 0, 0, 0);
        xact("R5 dword misaligned",     8'd2, 8'h08, 8'h02, 2'd2, 0, 0, 0, 0, 0, 0);
        xact("R5 write misaligned",     8'd0, {5'd12, 3'd0}, 8'h03, 2'd2, 1, 32'h5, 0, 0, 0, 0);
        xact("R8 abort dword read",     8'd0, {5'd2, 3'd0}, 8'h08, 2'd2, 0, 0, 1, 1, 32'h1234_0000, 0);
        xact("R8 abort byte read",      8'd3, 8'h20, 8'h0E, 2'd0, 0, 0, 0, 1, 32'h0000_0000, 0);
        xact("R8 abort write ignored",  8'd0, {5'd4, 3'd0}, 8'h0C, 2'd2, 1, 32'h7777_8888, 0, 1, 0, 0);
        xact("R9 busy noise",           8'd7, 8'h31, 8'h2A, 2'd1, 0, 0, 3, 0, 32'h5566_7788, 1);
        xact("R1 t0 after noise",       8'd0, {5'd6, 3'd5}, 8'hFD, 2'd0, 0, 0, 0, 0, 32'h4433_2211, 0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule